// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds a small bank of independent 32-bit countdown timers behind a plain register bus: an address, write data, a write strobe and combinational read data. Each channel has a control register, a load-value register and a read-only live counter. The live counter drops by one on every tick that the channel's source select lets through. When it goes from 1 to 0, a sticky pending flag is raised. Software normally reads the live counter and inverts it to get a rising time base. One channel is usually left free-running as a clock source, and another is armed repeatedly for one-shot events.

A channel either stops at zero (single mode) or, with its repeat bit set, loads the load value again on the next tick after zero. A separate bit makes any write to the load-value register copy the new value straight into the live counter, which starts a fresh countdown. Software parks a channel as far out as possible by loading all ones.

Every writable register also answers at three alias addresses. At those addresses a write ORs the data into the register, clears the bits that are ones in the data, or toggles them. This lets software acknowledge an interrupt or flip the enable without a read-modify-write. Each channel's pending flag is gated by its own enable, and the gated results are ORed onto one interrupt line. A read-only identification word reports the major revision.

Top module: `tick_timer_bank`

## Requirements
- R1: While the reset input is low, and after it is released, every control, load-value, live-counter and global register reads 0 and `irq_o` is 0.
- R2: Word map, with channel n counted from 0: global register at 0x000, channel control at 0x20+n*0x40, live counter at 0x30+n*0x40, load value at 0x40+n*0x40, identification at 0x1F0. In the control register only bits [3:0], 6, 7, 14 and 15 exist; the other bits read 0. Unmapped addresses read 0, and so does any address whose bits [1:0] are not 00.
- R3: Address bits [3:2] choose the write action on the global, control and load-value registers: 00 overwrites, 01 ORs the data in, 10 clears the bits set in the data, 11 toggles them.
- R4: Control bits [3:0] choose the tick: 0xF ticks every clock, 0xB ticks on each clock where `slow_tick_i` is high, and any other code stops the counter.
- R5: Each tick lowers a nonzero live counter by exactly one in the following cycle. With the repeat bit clear, a counter at 0 stays at 0.
- R6: With control bit 6 (repeat) set, a tick that finds the counter at 0 loads the load value, so one period lasts load+1 ticks.
- R7: With control bit 7 (immediate load) set, a write to the load-value register also puts the written value into the live counter on the same edge, and this takes precedence over a tick. With bit 7 clear, such a write leaves the live counter unchanged.
- R8: Control bit 15 (pending) is set by a tick that moves the counter from 1 to 0. It then stays set until software writes it to 0, for example by writing 0x8000 to the clear alias.
- R9: Control bit 14 enables the channel's interrupt. `irq_o` is high exactly when some channel has both bit 14 and bit 15 set.
- R10: Writes to the live-counter address have no effect.
- R11: The identification word reads 0x0200_0000 (major revision 2 in bits [31:24]), and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | Slow reference strobe, one clock wide per tick |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per clock |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | OR of all enabled pending flags |

## Verification
The checker watches every cycle for the counter rules: the counter holds without a tick, steps down by exactly one on a tick, reloads from the load value after zero when repeat is set, and stays at zero in single mode. It also checks that the pending flag is raised on the 1-to-0 step and that it only falls after a control write, and that the identification word is constant. The alias arithmetic, the field mask, the tick-source choice, precedence of an immediate load and interrupt gating by the enable are shown only by the bench's register sequences and timed countdowns.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  localparam logic [3:0] SEL_SLOW = 4'hB;
  localparam logic [3:0] SEL_FAST = 4'hF;

  localparam int unsigned BIT_RELOAD = 6;
  localparam int unsigned BIT_UPDATE = 7;
  localparam int unsigned BIT_IEN    = 14;
  localparam int unsigned BIT_FLAG   = 15;

  localparam logic [REG_W-1:0] CTRL_MASK   = 32'h0000_C0CF;
  localparam logic [REG_W-1:0] VERSION_VAL = 32'h0200_0000;

  localparam int unsigned GLOBAL_OFF  = 'h000;
  localparam int unsigned VERSION_OFF = 'h1F0;
  localparam int unsigned CH_STRIDE   = 'h40;
  localparam int unsigned CTRL_OFF0   = 'h20;
  localparam int unsigned COUNT_OFF0  = 'h30;
  localparam int unsigned FIXED_OFF0  = 'h40;

  function automatic logic [REG_W-1:0] alias_apply(input alias_op_e op,
                                                   input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] d);
    logic [REG_W-1:0] r;
    case (op)
      OP_SET:  r = cur | d;
      OP_CLR:  r = cur & ~d;
      OP_TOG:  r = cur ^ d;
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tmr_alias_reg.sv
module tmr_alias_reg
  import tmr_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = 32'hFFFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  alias_op_e        op_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] val_d;

  always_comb begin
    val_d = alias_apply(op_i, q_o, wdata_i) & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= val_d;
  end
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  logic [3:0] sel_i,
  input  logic       slow_i,
  output logic       tick_o
);
  always_comb begin
    case (sel_i)
      SEL_FAST: tick_o = 1'b1;
      SEL_SLOW: tick_o = slow_i;
      default:  tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_tick_i,
  input  logic             ctrl_we_i,
  input  logic             fixed_we_i,
  input  alias_op_e        op_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] fixed_o,
  output logic [REG_W-1:0] count_o,
  output logic             tick_o,
  output logic             irq_o
);
  logic [REG_W-1:0] ctrl_d, ctrl_wval, fixed_wval, cnt_d;
  logic             load_now, expire, cnt_en;

  tmr_tick_sel u_sel (
    .sel_i  (ctrl_o[3:0]),
    .slow_i (slow_tick_i),
    .tick_o (tick_o)
  );

  tmr_alias_reg #(.MASK(32'hFFFF_FFFF)) u_fixed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fixed_we_i),
    .op_i    (op_i),
    .wdata_i (wdata_i),
    .q_o     (fixed_o)
  );

  // next state: control register, pending flag, live counter
  always_comb begin
    ctrl_wval  = alias_apply(op_i, ctrl_o, wdata_i) & CTRL_MASK;
    fixed_wval = alias_apply(op_i, fixed_o, wdata_i);
    load_now   = fixed_we_i & ctrl_o[BIT_UPDATE];
    expire     = tick_o & (count_o == 32'd1) & ~load_now;

    ctrl_d = ctrl_we_i ? ctrl_wval : ctrl_o;
    if (expire) ctrl_d[BIT_FLAG] = 1'b1;

    cnt_en = load_now | tick_o;
    if (load_now)             cnt_d = fixed_wval;
    else if (count_o != '0)   cnt_d = count_o - 32'd1;
    else if (ctrl_o[BIT_RELOAD]) cnt_d = fixed_o;
    else                      cnt_d = count_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else         ctrl_o <= ctrl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (cnt_en) count_o <= cnt_d;
  end

  assign irq_o = ctrl_o[BIT_FLAG] & ctrl_o[BIT_IEN];
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              bus_we_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] GLOBAL_A  = ADDR_W'(GLOBAL_OFF);
  localparam logic [ADDR_W-1:0] VERSION_A = ADDR_W'(VERSION_OFF);

  logic                          rst_n_sync;
  logic                          acc_ok, wr_ok;
  alias_op_e                     op;
  logic [ADDR_W-1:0]             base;
  logic [REG_W-1:0]              glob_q;
  logic [NUM_CH-1:0][REG_W-1:0]  ch_ctrl, ch_fixed, ch_cnt;
  logic [NUM_CH-1:0]             ch_tick, ch_irq, ch_ctrl_we, ch_fixed_we;

  tmr_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  assign acc_ok = (bus_addr_i[1:0] == 2'b00);
  assign wr_ok  = bus_we_i & acc_ok;
  assign op     = alias_op_e'(bus_addr_i[3:2]);
  assign base   = {bus_addr_i[ADDR_W-1:4], 4'h0};

  tmr_alias_reg #(.MASK(32'hFFFF_FFFF)) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .we_i    (wr_ok & (base == GLOBAL_A)),
    .op_i    (op),
    .wdata_i (bus_wdata_i),
    .q_o     (glob_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_OFF0  + c * CH_STRIDE);
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(FIXED_OFF0 + c * CH_STRIDE);

    assign ch_ctrl_we[c]  = wr_ok & (base == CA);
    assign ch_fixed_we[c] = wr_ok & (base == FA);

    tmr_channel u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_n_sync),
      .slow_tick_i (slow_tick_i),
      .ctrl_we_i   (ch_ctrl_we[c]),
      .fixed_we_i  (ch_fixed_we[c]),
      .op_i        (op),
      .wdata_i     (bus_wdata_i),
      .ctrl_o      (ch_ctrl[c]),
      .fixed_o     (ch_fixed[c]),
      .count_o     (ch_cnt[c]),
      .tick_o      (ch_tick[c]),
      .irq_o       (ch_irq[c])
    );
  end

  // read mux, combinational on the presented address
  always_comb begin
    bus_rdata_o = '0;
    if (acc_ok) begin
      if (base == GLOBAL_A)  bus_rdata_o = glob_q;
      if (base == VERSION_A) bus_rdata_o = VERSION_VAL;
      for (int c = 0; c < NUM_CH; c++) begin
        if (base == ADDR_W'(CTRL_OFF0  + c * CH_STRIDE)) bus_rdata_o = ch_ctrl[c];
        if (base == ADDR_W'(COUNT_OFF0 + c * CH_STRIDE)) bus_rdata_o = ch_cnt[c];
        if (base == ADDR_W'(FIXED_OFF0 + c * CH_STRIDE)) bus_rdata_o = ch_fixed[c];
      end
    end
  end

  assign irq_o = |ch_irq;
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 12
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_CH-1:0][REG_W-1:0] ch_ctrl,
  input logic [NUM_CH-1:0][REG_W-1:0] ch_fixed,
  input logic [NUM_CH-1:0][REG_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0]            ch_tick,
  input logic [NUM_CH-1:0]            ch_ctrl_we,
  input logic [NUM_CH-1:0]            ch_fixed_we,
  input logic [ADDR_W-1:0]            bus_addr_i,
  input logic [31:0]                  bus_rdata_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ch_tick[c] && !ch_fixed_we[c]) |=> $stable(ch_cnt[c])); // R5
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_tick[c] && ch_cnt[c] != '0 && !ch_fixed_we[c]) |=> (ch_cnt[c] == $past(ch_cnt[c]) - 32'd1)); // R5
    AST_SINGLE_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_tick[c] && ch_cnt[c] == '0 && !ch_ctrl[c][BIT_RELOAD] && !ch_fixed_we[c]) |=> (ch_cnt[c] == '0)); // R5
    AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_tick[c] && ch_cnt[c] == '0 && ch_ctrl[c][BIT_RELOAD] && !ch_fixed_we[c]) |=> (ch_cnt[c] == $past(ch_fixed[c]))); // R6
    AST_FLAG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_tick[c] && ch_cnt[c] == 32'd1 && !ch_fixed_we[c]) |=> ch_ctrl[c][BIT_FLAG]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_ctrl[c][BIT_FLAG] && !ch_ctrl_we[c]) |=> ch_ctrl[c][BIT_FLAG]); // R8
  end

  AST_VERSION_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(VERSION_OFF)) |-> (bus_rdata_o == VERSION_VAL)); // R11
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_sync),
  .ch_ctrl     (ch_ctrl),
  .ch_fixed    (ch_fixed),
  .ch_cnt      (ch_cnt),
  .ch_tick     (ch_tick),
  .ch_ctrl_we  (ch_ctrl_we),
  .ch_fixed_we (ch_fixed_we),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/tick_timer_bank_tb_top.sv
`timescale 1ns/10ps
module tick_timer_bank_tb_top;
  logic        clk, rst_n, slow;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        we, irq;
  int          total, fails;

  tick_timer_bank #(.NUM_CH(2), .ADDR_W(12)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .slow_tick_i (slow),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_we_i    (we),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // entry: {is_write, addr, data_or_expected, requirement number}
  localparam int NV = 27;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'h1234_5678, 4'd3},
    {1'b0, 12'h000, 32'h1234_5678, 4'd3},  // R3 overwrite
    {1'b1, 12'h004, 32'h0000_0001, 4'd3},
    {1'b0, 12'h000, 32'h1234_5679, 4'd3},  // R3 set alias
    {1'b1, 12'h008, 32'h0000_0010, 4'd3},
    {1'b0, 12'h000, 32'h1234_5669, 4'd3},  // R3 clear alias
    {1'b1, 12'h00C, 32'hFFFF_0000, 4'd3},
    {1'b0, 12'h000, 32'hEDCB_5669, 4'd3},  // R3 toggle alias
    {1'b1, 12'h060, 32'hFFFF_FFFF, 4'd2},
    {1'b0, 12'h060, 32'h0000_C0CF, 4'd2},  // R2 field mask
    {1'b1, 12'h060, 32'h0000_0000, 4'd3},
    {1'b0, 12'h060, 32'h0000_0000, 4'd3},
    {1'b1, 12'h040, 32'h0000_0055, 4'd7},
    {1'b0, 12'h040, 32'h0000_0055, 4'd7},
    {1'b0, 12'h030, 32'h0000_0000, 4'd7},  // R7 no load without bit 7
    {1'b1, 12'h030, 32'h0000_0099, 4'd10},
    {1'b0, 12'h030, 32'h0000_0000, 4'd10}, // R10
    {1'b0, 12'h1F0, 32'h0200_0000, 4'd11},
    {1'b1, 12'h1F0, 32'hFFFF_FFFF, 4'd11},
    {1'b0, 12'h1F0, 32'h0200_0000, 4'd11}, // R11
    {1'b0, 12'h0F0, 32'h0000_0000, 4'd2},
    {1'b1, 12'h080, 32'h0000_0077, 4'd2},
    {1'b0, 12'h080, 32'h0000_0077, 4'd2},
    {1'b0, 12'h040, 32'h0000_0055, 4'd2},
    {1'b1, 12'h084, 32'h0000_0008, 4'd3},
    {1'b0, 12'h080, 32'h0000_007F, 4'd3},
    {1'b0, 12'h002, 32'h0000_0000, 4'd2}   // R2 misaligned
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a; we = 1'b0;
    #0.2;
    chk(tag, rdata, exp);
  endtask

  task automatic irqchk(input string tag, input logic exp);
    #0.2;
    chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    slow = 1'b1;
    @(negedge clk);
    slow = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    total = 0; fails = 0;
    rst_n = 1'b0; slow = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rdchk("R1 global after reset", 12'h000, 32'h0);
    rdchk("R1 ch0 ctrl after reset", 12'h020, 32'h0);
    irqchk("R1 irq after reset", 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) wr(VEC[i][47:36], VEC[i][35:4]);
      else rdchk($sformatf("R%0d table step %0d", VEC[i][3:0], i), VEC[i][47:36], VEC[i][35:4]);
    end
    idle(1);

    // single-shot countdown on the fast tick, channel 0
    wr(12'h020, 32'h0000_4080);
    wr(12'h040, 32'd5);
    rdchk("R7 immediate load", 12'h030, 32'd5);
    wr(12'h024, 32'h0000_000F);
    rdchk("R4 no tick before select takes effect", 12'h030, 32'd5);
    idle(3);
    rdchk("R5 three steps", 12'h030, 32'd2);
    irqchk("R9 idle before expiry", 1'b0);
    idle(2);
    rdchk("R8 reached zero", 12'h030, 32'd0);
    irqchk("R9 raised on expiry", 1'b1);
    rdchk("R8 flag set", 12'h020, 32'h0000_C08F);
    idle(3);
    rdchk("R5 single mode stays at zero", 12'h030, 32'd0);
    rdchk("R8 flag sticky", 12'h020, 32'h0000_C08F);
    wr(12'h028, 32'h0000_8000);
    rdchk("R8 acknowledge", 12'h020, 32'h0000_408F);
    irqchk("R9 dropped after acknowledge", 1'b0);

    // park and precedence of immediate load over a tick
    wr(12'h040, 32'hFFFF_FFFF);
    rdchk("R7 load wins over tick", 12'h030, 32'hFFFF_FFFF);
    idle(1);
    rdchk("R5 step from parked value", 12'h030, 32'hFFFF_FFFE);
    wr(12'h020, 32'h0);

    // repeat mode on the slow strobe, channel 1
    wr(12'h060, 32'h0000_004B);
    wr(12'h080, 32'd2);
    idle(3);
    rdchk("R4 slow select idle without strobe", 12'h070, 32'd0);
    pulse();
    rdchk("R6 reload from zero", 12'h070, 32'd2);
    pulse();
    pulse();
    rdchk("R5 slow countdown to zero", 12'h070, 32'd0);
    rdchk("R8 flag on slow expiry", 12'h060, 32'h0000_804B);
    irqchk("R9 masked flag", 1'b0);
    wr(12'h064, 32'h0000_4000);
    irqchk("R9 enable reveals flag", 1'b1);
    pulse();
    rdchk("R6 next period", 12'h070, 32'd2);
    wr(12'h060, 32'h0000_4043);
    idle(2);
    pulse();
    rdchk("R4 unsupported select halts", 12'h070, 32'd2);

    // reset in the middle of activity
    rst_n = 1'b0;
    rdchk("R1 ctrl in reset", 12'h060, 32'h0);
    rdchk("R1 count in reset", 12'h070, 32'h0);
    irqchk("R1 irq in reset", 1'b0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    rdchk("R1 global after second reset", 12'h000, 32'h0);
    rdchk("R1 load value after second reset", 12'h080, 32'h0);

    summary();
    $finish;
  end
endmodule